// File: doc/BRIEF.md
# Shadow Register Set Selector

This block chooses which bank of general-purpose registers a processor core is working in. It switches banks when an exception or interrupt is taken and switches back on exception return. The core drives an entry strobe, a return strobe and the active interrupt mode. With them come the index of the vectored line being serviced, and the set number and priority level offered by an external interrupt controller.

The block records the bank that was active before each entry so that a return can restore it. Software reads and writes the control and map registers through a small coprocessor-style port, and can save and restore the previous-set field when handlers nest. A banked register file is included. It has two combinational read ports and one write port, and it is always addressed through the current set.

Top module: `srs_selector`

## Requirements
- R1: After reset, the current set, previous set, exception set, captured external set and map register are all zero. The control register (cfg_sel=0) reads NUM_SETS-1 at bits 29:26 and zero at every bit that no field defines.
- R2: The control register holds the current set at bits 3:0 (read-only), the previous set at bits 9:6 (read/write), the exception set at bits 15:12 (read/write) and the captured external set at bits 21:18 (read-only). The map register (cfg_sel=1) is a full 32-bit read/write register.
- R3: On exc_enter, at the same clock edge, prev_set takes the old cur_set and cur_set takes the newly selected set.
- R4: On exc_return without exc_enter, cur_set is reloaded from the previous-set field. If both strobes are high, entry wins.
- R5: In classic mode (int_mode=0, and the reserved code 3), every exception, interrupts included, selects the exception-set field. A value of 0 keeps bank 0.
- R6: In vectored mode (int_mode=1), an interrupt selects map bits 4*L+3:4*L, where L is the line given on vec_line. A non-interrupt exception selects the exception-set field.
- R7: In external mode (int_mode=2), an interrupt with nonzero ext_level selects ext_set and ignores the map. The captured-external field takes that set and holds it until the next such interrupt. Any other entry in this mode selects the exception-set field.
- R8: A set number above NUM_SETS-1, whether selected on entry or restored on return, becomes set 0.
- R9: Register 0 reads as zero in every bank, and writes to it are discarded.
- R10: When a write and a read hit the same register in the same cycle, the read returns the data being written.
- R11: Each bank keeps its own contents. A write made while one set is current cannot be seen from another set.
- R12: If a software write to the control register lands in the same cycle as exc_enter, the hardware copy of cur_set into the previous-set field wins. The exception-set field still takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_sel | input | 1 | 0 selects the control register, 1 selects the map register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for the selected register |
| exc_enter | input | 1 | Exception or interrupt entry strobe |
| exc_return | input | 1 | Exception return strobe |
| int_mode | input | 2 | 0 classic, 1 vectored, 2 external, 3 treated as classic |
| is_irq | input | 1 | The entry being taken is an interrupt |
| vec_line | input | 3 | Vectored interrupt line being serviced |
| ext_set | input | 4 | Set number proposed by the external controller |
| ext_level | input | 6 | Request level from the external controller, 0 means no request |
| cur_set | output | 4 | Current register set |
| prev_set | output | 4 | Previous register set field |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 5 | Register file write address |
| rf_wdata | input | 32 | Register file write data |
| rf_raddr_a | input | 5 | Read port A address |
| rf_rdata_a | output | 32 | Read port A data |
| rf_raddr_b | input | 5 | Read port B address |
| rf_rdata_b | output | 32 | Read port B data |

## Verification
The bench nests interrupts two deep and checks that each return restores the right bank. A selector that failed to save the old set on entry would return to the wrong bank. In external mode the controller offers a set that differs from the map entry, so a design that consulted the map there would land on the wrong bank. The bench also drives a level-zero request and expects the captured field to keep its old value. A design that refilled that field on every entry would show the new value instead.

Out-of-range numbers reach the selector by three routes: a programmed exception set, a restored previous set and a controller proposal. An unclamped design would leave cur_set beyond the implemented banks. The bench also checks the register-file bypass, register 0 and bank isolation. In each case a wrong design returns stale data, a nonzero value for register 0, or the other bank's contents.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int SET_W   = 4;
  localparam int LINES   = 8;
  localparam int CFG_W   = 32;

  localparam int CUR_LSB  = 0;
  localparam int PREV_LSB = 6;
  localparam int ESS_LSB  = 12;
  localparam int EXT_LSB  = 18;
  localparam int HSS_LSB  = 26;

  typedef enum logic [1:0] {
    MODE_CLASSIC  = 2'd0,
    MODE_VECTOR   = 2'd1,
    MODE_EXTERNAL = 2'd2,
    MODE_RSVD     = 2'd3
  } irq_mode_e;

  // Any number beyond the top implemented set falls back to bank 0.
  function automatic logic [SET_W-1:0] clamp_set(input logic [SET_W-1:0] s,
                                                 input logic [SET_W-1:0] top);
    return (s > top) ? '0 : s;
  endfunction

  function automatic logic [SET_W-1:0] map_field(input logic [CFG_W-1:0] map,
                                                 input logic [2:0] line);
    return map[line*SET_W +: SET_W];
  endfunction

  function automatic logic [CFG_W-1:0] pack_ctrl(input logic [SET_W-1:0] top,
                                                 input logic [SET_W-1:0] ext,
                                                 input logic [SET_W-1:0] ess,
                                                 input logic [SET_W-1:0] prev,
                                                 input logic [SET_W-1:0] cur);
    logic [CFG_W-1:0] w;
    w = '0;
    w[HSS_LSB  +: SET_W] = top;
    w[EXT_LSB  +: SET_W] = ext;
    w[ESS_LSB  +: SET_W] = ess;
    w[PREV_LSB +: SET_W] = prev;
    w[CUR_LSB  +: SET_W] = cur;
    return w;
  endfunction
endpackage

// File: rtl/srs_set_pick.sv
module srs_set_pick
  import srs_pkg::*;
#(
  parameter int NUM_SETS = 4
) (
  input  logic [1:0]       mode,
  input  logic             is_irq,
  input  logic [2:0]       line,
  input  logic [SET_W-1:0] ext_set,
  input  logic [5:0]       ext_level,
  input  logic [SET_W-1:0] ess,
  input  logic [CFG_W-1:0] map,
  output logic [SET_W-1:0] pick,
  output logic             ext_take
);
  localparam logic [SET_W-1:0] TOP = SET_W'(NUM_SETS - 1);

  logic [SET_W-1:0] raw;

  always_comb begin
    ext_take = 1'b0;
    raw      = ess;
    unique case (irq_mode_e'(mode))
      MODE_VECTOR: begin
        if (is_irq) raw = map_field(map, line);
      end
      MODE_EXTERNAL: begin
        if (is_irq && (ext_level != '0)) begin
          raw      = ext_set;
          ext_take = 1'b1;
        end
      end
      default: raw = ess;
    endcase
    pick = clamp_set(raw, TOP);
  end
endmodule

// File: rtl/srs_ctrl_regs.sv
module srs_ctrl_regs
  import srs_pkg::*;
#(
  parameter int NUM_SETS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             exc_enter,
  input  logic             exc_return,
  input  logic [SET_W-1:0] entry_set,
  input  logic             ext_take,
  output logic [SET_W-1:0] cur_q,
  output logic [SET_W-1:0] prev_q,
  output logic [SET_W-1:0] ess_q,
  output logic [SET_W-1:0] ext_q,
  output logic [CFG_W-1:0] map_q
);
  localparam logic [SET_W-1:0] TOP = SET_W'(NUM_SETS - 1);

  logic wr_ctrl, wr_map;
  assign wr_ctrl = cfg_we && !cfg_sel;
  assign wr_map  = cfg_we &&  cfg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      ess_q  <= '0;
      ext_q  <= '0;
      map_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ess_q  <= cfg_wdata[ESS_LSB +: SET_W];
        if (!exc_enter) prev_q <= cfg_wdata[PREV_LSB +: SET_W];
      end
      if (wr_map) map_q <= cfg_wdata;
      if (exc_enter) begin
        prev_q <= cur_q;
        cur_q  <= entry_set;
        if (ext_take) ext_q <= entry_set;
      end else if (exc_return) begin
        cur_q <= clamp_set(prev_q, TOP);
      end
    end
  end

  assign cfg_rdata = cfg_sel ? map_q : pack_ctrl(TOP, ext_q, ess_q, prev_q, cur_q);
endmodule

// File: rtl/srs_bank_rf.sv
module srs_bank_rf
  import srs_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                        clk,
  input  logic [SET_W-1:0]            bank,
  input  logic                        we,
  input  logic [$clog2(NUM_REGS)-1:0] waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [$clog2(NUM_REGS)-1:0] raddr_a,
  output logic [DATA_W-1:0]           rdata_a,
  input  logic [$clog2(NUM_REGS)-1:0] raddr_b,
  output logic [DATA_W-1:0]           rdata_b
);
  localparam int AW    = $clog2(NUM_REGS);
  localparam int DEPTH = NUM_SETS * NUM_REGS;
  localparam int IW    = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_live;

  function automatic logic [IW-1:0] flat_idx(input logic [SET_W-1:0] b,
                                             input logic [AW-1:0] a);
    return IW'(b) * IW'(NUM_REGS) + IW'(a);
  endfunction

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_live) mem[flat_idx(bank, waddr)] <= wdata;
  end

  logic [AW-1:0]     rd_addr [2];
  logic [DATA_W-1:0] rd_data [2];
  assign rd_addr[0] = raddr_a;
  assign rd_addr[1] = raddr_b;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (rd_addr[p] == '0)                        rd_data[p] = '0;
      else if (wr_live && (waddr == rd_addr[p]))   rd_data[p] = wdata;
      else                                         rd_data[p] = mem[flat_idx(bank, rd_addr[p])];
    end
  end

  assign rdata_a = rd_data[0];
  assign rdata_b = rd_data[1];
endmodule

// File: rtl/srs_selector.sv
module srs_selector
  import srs_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        exc_enter,
  input  logic        exc_return,
  input  logic [1:0]  int_mode,
  input  logic        is_irq,
  input  logic [2:0]  vec_line,
  input  logic [3:0]  ext_set,
  input  logic [5:0]  ext_level,
  output logic [3:0]  cur_set,
  output logic [3:0]  prev_set,
  input  logic        rf_we,
  input  logic [4:0]  rf_waddr,
  input  logic [31:0] rf_wdata,
  input  logic [4:0]  rf_raddr_a,
  output logic [31:0] rf_rdata_a,
  input  logic [4:0]  rf_raddr_b,
  output logic [31:0] rf_rdata_b
);
  // Internal events brought out as named wires for the checker.
  logic [SET_W-1:0] entry_set;
  logic             ext_take;
  logic [SET_W-1:0] ess_q, ext_q;
  logic [CFG_W-1:0] map_q;

  srs_set_pick #(.NUM_SETS(NUM_SETS)) u_pick (
    .mode(int_mode), .is_irq(is_irq), .line(vec_line),
    .ext_set(ext_set), .ext_level(ext_level),
    .ess(ess_q), .map(map_q),
    .pick(entry_set), .ext_take(ext_take)
  );

  srs_ctrl_regs #(.NUM_SETS(NUM_SETS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .exc_enter(exc_enter), .exc_return(exc_return),
    .entry_set(entry_set), .ext_take(ext_take),
    .cur_q(cur_set), .prev_q(prev_set), .ess_q(ess_q), .ext_q(ext_q), .map_q(map_q)
  );

  srs_bank_rf #(.NUM_SETS(NUM_SETS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .bank(cur_set),
    .we(rf_we), .waddr(rf_waddr[$clog2(NUM_REGS)-1:0]), .wdata(rf_wdata[DATA_W-1:0]),
    .raddr_a(rf_raddr_a[$clog2(NUM_REGS)-1:0]), .rdata_a(rf_rdata_a[DATA_W-1:0]),
    .raddr_b(rf_raddr_b[$clog2(NUM_REGS)-1:0]), .rdata_b(rf_rdata_b[DATA_W-1:0])
  );
endmodule

// File: rtl/srs_selector_chk.sv
module srs_selector_chk
  import srs_pkg::*;
#(
  parameter int NUM_SETS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_enter,
  input logic             exc_return,
  input logic [SET_W-1:0] entry_set,
  input logic             ext_take,
  input logic [SET_W-1:0] ext_q,
  input logic [SET_W-1:0] cur_set,
  input logic [SET_W-1:0] prev_set,
  input logic [4:0]       rf_raddr_a,
  input logic [31:0]      rf_rdata_a,
  input logic [4:0]       rf_raddr_b,
  input logic [31:0]      rf_rdata_b
);
  localparam logic [SET_W-1:0] TOP = SET_W'(NUM_SETS - 1);

  p_entry_saves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> prev_set == $past(cur_set));

  p_entry_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> cur_set == $past(entry_set));

  p_return_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter) |=> cur_set == clamp_set($past(prev_set), TOP));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_enter && !exc_return) |=> $stable(cur_set));

  p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_set <= TOP);

  p_ext_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_enter && ext_take) |=> $stable(ext_q));

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_raddr_a == 5'd0) |-> (rf_rdata_a == 32'd0));

  p_zero_reg_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_raddr_b == 5'd0) |-> (rf_rdata_b == 32'd0));
endmodule

bind srs_selector srs_selector_chk #(.NUM_SETS(NUM_SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_return(exc_return),
  .entry_set(entry_set), .ext_take(ext_take), .ext_q(ext_q),
  .cur_set(cur_set), .prev_set(prev_set),
  .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
  .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b)
);

// File: tb/tb_srs_selector.sv
`timescale 1ns/1ps
module tb_srs_selector;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        exc_enter, exc_return;
  logic [1:0]  int_mode;
  logic        is_irq;
  logic [2:0]  vec_line;
  logic [3:0]  ext_set;
  logic [5:0]  ext_level;
  logic [3:0]  cur_set, prev_set;
  logic        rf_we;
  logic [4:0]  rf_waddr, rf_raddr_a, rf_raddr_b;
  logic [31:0] rf_wdata, rf_rdata_a, rf_rdata_b;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  srs_selector dut (.*);

  typedef struct packed {
    logic [1:0] mode;
    logic       irq;
    logic [2:0] line;
    logic [3:0] eset;
    logic [5:0] elvl;
    logic       ent;
    logic       ret;
    logic [3:0] ecur;
    logic [3:0] eprev;
  } vec_t;

  // ESS=2, map lines 0..7 -> 2,1,3,0,1,2,0,3 ; four sets implemented
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 3'd0, 4'd0, 6'd0, 1'b1, 1'b0, 4'd2, 4'd0}, // R5 classic irq -> ESS
    '{2'd0, 1'b0, 3'd0, 4'd0, 6'd0, 1'b0, 1'b1, 4'd0, 4'd0}, // R4 return
    '{2'd1, 1'b1, 3'd1, 4'd0, 6'd0, 1'b1, 1'b0, 4'd1, 4'd0}, // R6 line 1
    '{2'd1, 1'b1, 3'd2, 4'd0, 6'd0, 1'b1, 1'b0, 4'd3, 4'd1}, // R6 nested line 2
    '{2'd1, 1'b0, 3'd0, 4'd0, 6'd0, 1'b0, 1'b1, 4'd1, 4'd1}, // R4 unwind
    '{2'd1, 1'b0, 3'd5, 4'd0, 6'd0, 1'b1, 1'b0, 4'd2, 4'd1}, // R6 non-irq -> ESS
    '{2'd2, 1'b1, 3'd1, 4'd3, 6'd5, 1'b1, 1'b0, 4'd3, 4'd2}, // R7 ext set, map ignored
    '{2'd2, 1'b1, 3'd0, 4'd1, 6'd0, 1'b1, 1'b0, 4'd2, 4'd3}, // R7 level 0 -> ESS
    '{2'd2, 1'b1, 3'd0, 4'd7, 6'd1, 1'b1, 1'b0, 4'd0, 4'd2}, // R8 ext out of range
    '{2'd1, 1'b1, 3'd3, 4'd0, 6'd0, 1'b1, 1'b0, 4'd0, 4'd0}, // R6 map zero
    '{2'd3, 1'b0, 3'd0, 4'd0, 6'd0, 1'b1, 1'b1, 4'd2, 4'd0}  // R4/R5 both strobes, entry wins
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic take(input logic [1:0] m, input logic irq, input logic [2:0] ln,
                      input logic [3:0] es, input logic [5:0] lv,
                      input logic en, input logic rt);
    int_mode = m; is_irq = irq; vec_line = ln; ext_set = es; ext_level = lv;
    exc_enter = en; exc_return = rt;
    @(negedge clk);
    exc_enter = 1'b0; exc_return = 1'b0;
  endtask

  task automatic cfg_wr(input logic sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rf_wr(input logic [4:0] a, input logic [31:0] d);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    exc_enter = 0; exc_return = 0; int_mode = 0; is_irq = 0;
    vec_line = 0; ext_set = 0; ext_level = 0;
    rf_we = 0; rf_waddr = 0; rf_wdata = 0; rf_raddr_a = 0; rf_raddr_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfg_sel = 1'b0; #1;
    chk("R1 ctrl reset", cfg_rdata, 32'h0C00_0000);
    cfg_sel = 1'b1; #1;
    chk("R1 map reset", cfg_rdata, 32'h0);
    chk("R1 cur reset", {28'd0, cur_set}, 32'd0);
    chk("R1 prev reset", {28'd0, prev_set}, 32'd0);
    @(negedge clk);

    // R2 field layout, read-only fields untouched
    cfg_wr(1'b0, 32'hFFFF_FFFF);
    cfg_sel = 1'b0; #1;
    chk("R2 ctrl layout", cfg_rdata, 32'h0C00_F3C0);

    // R8 exception set 15 clamps to 0
    @(negedge clk);
    take(2'd0, 1'b0, 3'd0, 4'd0, 6'd0, 1'b1, 1'b0);
    chk("R8 ess clamp cur", {28'd0, cur_set}, 32'd0);
    cfg_wr(1'b0, 32'h0000_03C0);
    chk("R2 prev written", {28'd0, prev_set}, 32'd15);
    take(2'd0, 1'b0, 3'd0, 4'd0, 6'd0, 1'b0, 1'b1);
    chk("R8 return clamp cur", {28'd0, cur_set}, 32'd0);

    // setup for the table
    cfg_wr(1'b0, 32'h0000_2000);
    cfg_wr(1'b1, 32'h3021_0312);
    cfg_sel = 1'b1; #1;
    chk("R2 map readback", cfg_rdata, 32'h3021_0312);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      take(VEC[i].mode, VEC[i].irq, VEC[i].line, VEC[i].eset, VEC[i].elvl,
           VEC[i].ent, VEC[i].ret);
      chk($sformatf("R3 vec %0d cur", i), {28'd0, cur_set}, {28'd0, VEC[i].ecur});
      chk($sformatf("R3 vec %0d prev", i), {28'd0, prev_set}, {28'd0, VEC[i].eprev});
    end
    // bring back to set 0 / prev 0
    cfg_wr(1'b0, 32'h0000_2000);
    take(2'd0, 1'b0, 3'd0, 4'd0, 6'd0, 1'b0, 1'b1);
    chk("R4 back to set 0", {28'd0, cur_set}, 32'd0);

    // R7 capture and hold of external set
    take(2'd2, 1'b1, 3'd0, 4'd2, 6'd3, 1'b1, 1'b0);
    cfg_sel = 1'b0; #1;
    chk("R7 ext captured", cfg_rdata, 32'h0C08_2002);
    @(negedge clk);
    take(2'd1, 1'b1, 3'd0, 4'd3, 6'd3, 1'b1, 1'b0);
    cfg_sel = 1'b0; #1;
    chk("R7 ext held", cfg_rdata, 32'h0C08_2082);
    @(negedge clk);

    // R12 write collides with entry
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0000_1040;
    take(2'd0, 1'b0, 3'd0, 4'd0, 6'd0, 1'b1, 1'b0);
    cfg_we = 1'b0; #1;
    chk("R12 entry wins prev", {28'd0, prev_set}, 32'd2);
    chk("R12 ctrl after collide", cfg_rdata, 32'h0C08_1082);
    @(negedge clk);

    // register file: set 0 then set 1
    cfg_wr(1'b0, 32'h0000_1000);
    take(2'd0, 1'b0, 3'd0, 4'd0, 6'd0, 1'b0, 1'b1);
    chk("R4 restore set 0", {28'd0, cur_set}, 32'd0);
    rf_wr(5'd5, 32'hAAAA_0005);
    take(2'd0, 1'b1, 3'd0, 4'd0, 6'd0, 1'b1, 1'b0);
    chk("R5 classic ess 1", {28'd0, cur_set}, 32'd1);
    rf_wr(5'd5, 32'hBBBB_0005);
    rf_raddr_a = 5'd5; #1;
    chk("R11 set 1 data", rf_rdata_a, 32'hBBBB_0005);
    @(negedge clk);
    take(2'd0, 1'b0, 3'd0, 4'd0, 6'd0, 1'b0, 1'b1);
    rf_raddr_a = 5'd5; #1;
    chk("R11 set 0 data", rf_rdata_a, 32'hAAAA_0005);
    @(negedge clk);

    // R9 register 0
    rf_wr(5'd0, 32'hFFFF_FFFF);
    rf_raddr_a = 5'd0; rf_raddr_b = 5'd0; #1;
    chk("R9 reg0 port a", rf_rdata_a, 32'h0);
    chk("R9 reg0 port b", rf_rdata_b, 32'h0);
    @(negedge clk);

    // R10 bypass
    rf_we = 1'b1; rf_waddr = 5'd7; rf_wdata = 32'h1234_5678; rf_raddr_b = 5'd7; #1;
    chk("R10 bypass", rf_rdata_b, 32'h1234_5678);
    @(negedge clk);
    rf_we = 1'b0; #1;
    chk("R10 stored", rf_rdata_b, 32'h1234_5678);

    finish_run();
  end
endmodule